// File: doc/BRIEF.md
# Paged PMBus Command Register Store

This block holds the command registers of a power and temperature monitor that acts as a slave on an SMBus/PMBus link. A separate byte-level front end decodes each transaction and hands over a command code plus either a write payload with its byte count or a read request. The store answers reads one cycle later with up to two data bytes and a byte count. A page selector chooses one of 21 channel contexts. Contexts 0 to 15 are voltage rails and contexts 16 to 20 are temperature sensors, so temperature sensor *i* is reached on page *i*+16.

Each context keeps its own limits, margins, power-good thresholds, operation and on/off configuration, a vendor mode word, the latest measurement and, on voltage rails, the lowest voltage seen since reset. Measurements come from the analog path through a side port. They never come from the bus. Selecting the all-pages code turns writes to the on/off configuration and the vendor mode word into broadcasts over every context. Writes to read-only registers are dropped without complaint. Malformed or unknown commands raise an error pulse.

Top module: `pmbus_paged_regs`

## Requirements
- R1: After reset the page selector is 0, every upper fault and warn limit (over-voltage on rails, over-temperature on sensors) reads 0x7FFF, both under-voltage limits read 0, the lowest-voltage register reads 0x7FFF, rail readings are 0, sensor readings are 2500, and all other writable registers read 0.
- R2: A 16-bit register travels least significant byte first: `rd_data[7:0]`/`wr_data[7:0]` carry the first byte on the bus and bits 15:8 the second. Word reads report `rd_len`=2. Byte registers (PAGE 0x00, OPERATION 0x01, ON_OFF_CONFIG 0x02, CAPABILITY 0x19, VOUT_MODE 0x20, REVISION 0x98) report `rd_len`=1 with `rd_data[15:8]`=0.
- R3: PAGE, OPERATION, ON_OFF_CONFIG, margin high/low (0x25/0x26), over-voltage fault/warn (0x40/0x42), under-voltage warn/fault (0x43/0x44), power-good on/off (0x5E/0x5F), over-temperature fault/warn (0x4F/0x51) and vendor mode (0xD1) read back the value last written, held separately for each page.
- R4: A PAGE write takes effect only for values 0 to 20 or 0xFF. Any other value leaves the page selector unchanged.
- R5: With the page selector at 0xFF, a write to ON_OFF_CONFIG or vendor mode 0xD1 updates all 21 pages. Every other per-page write goes to page 0, reads use page 0, and PAGE reads back 0xFF.
- R6: Writes to CAPABILITY, VOUT_MODE, REVISION, READ_VOUT (0x8B), READ_TEMPERATURE_1 (0x8D) and the lowest-voltage register (0xD7) are discarded with no error, and later reads return the earlier value.
- R7: VOUT_MODE reads 0x40 (direct format), REVISION reads 0x11 and CAPABILITY reads 0x20 on every page.
- R8: A measurement for channel c below 21 sets that page's reading. On a rail page it also lowers the lowest-voltage register to the new value when the new value is smaller. Channels 21 and above are ignored.
- R9: A read of a command that the current page does not implement returns 0xFFFF with `rd_len`=2 and `rd_err`=1. Rail-only commands (0x25, 0x26, 0x40, 0x42 to 0x44, 0x5E, 0x5F, 0x8B, 0xD7) are not implemented on sensor pages, and sensor-only commands (0x4F, 0x51, 0x8D) are not implemented on rail pages. A write whose code is not implemented, or whose byte count differs from the register width, changes nothing and pulses `wr_err` one cycle later.
- R10: `rd_valid` is high exactly in the cycle after a cycle with `rd_en`. The reply reflects the state before any write or measurement in that same `rd_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 8 | Command code of the current access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_cnt | input | 2 | Data bytes in the write (1 or 2) |
| wr_data | input | 16 | Write payload, first bus byte in bits 7:0 |
| rd_en | input | 1 | Read request for one cycle |
| meas_valid | input | 1 | New measurement present |
| meas_chan | input | 5 | Channel index of the measurement (equals its page) |
| meas_value | input | 16 | Measured value |
| rd_valid | output | 1 | Read reply valid |
| rd_data | output | 16 | Read reply, first bus byte in bits 7:0 |
| rd_len | output | 2 | Reply byte count |
| rd_err | output | 1 | Read of an unimplemented command |
| wr_err | output | 1 | Rejected write, one cycle after the strobe |

## Verification
The assertions assume that the front end never raises `rd_en` and `wr_en` in the same cycle and that `wr_cnt` is 1 or 2 whenever `wr_en` is high. The stimulus issues one access at a time with idle cycles between them and drives every input on the falling edge. It sends measurements only in cycles with no bus access, except in one deliberate read-during-measurement case that checks the old value is returned. Channel numbers above 20 and a zero-length byte count appear only in the cases that check they are rejected.

// File: rtl/rmb_pkg.sv
package rmb_pkg;

  typedef enum logic [4:0] {
    F_NONE, F_PAGE, F_OPER, F_ONOFF, F_CAP, F_VMODE, F_REV,
    F_MHI, F_MLO, F_HIFLT, F_HIWRN, F_UVWRN, F_UVFLT,
    F_PGON, F_PGOFF, F_MEAS, F_MODE, F_VMIN
  } fld_e;

  typedef struct packed {
    logic known;
    logic word;
    logic wr_ok;
    fld_e fld;
  } dec_t;

  typedef struct packed {
    logic [7:0]  oper;
    logic [7:0]  onoff;
    logic [15:0] mhi;
    logic [15:0] mlo;
    logic [15:0] hflt;
    logic [15:0] hwrn;
    logic [15:0] uvw;
    logic [15:0] uvf;
    logic [15:0] pgon;
    logic [15:0] pgoff;
    logic [15:0] mode;
    logic [15:0] meas;
    logic [15:0] vmin;
  } ctx_t;

  function automatic dec_t mk(input logic k, input logic w, input logic wr, input fld_e f);
    dec_t d;
    d.known = k;
    d.word  = w;
    d.wr_ok = wr;
    d.fld   = f;
    return d;
  endfunction

  // command map; rail-only and sensor-only codes depend on the page kind
  function automatic dec_t decode_cmd(input logic [7:0] c, input logic temp);
    dec_t d;
    d = mk(1'b0, 1'b1, 1'b0, F_NONE);
    case (c)
      8'h00: d = mk(1'b1, 1'b0, 1'b1, F_PAGE);
      8'h01: d = mk(1'b1, 1'b0, 1'b1, F_OPER);
      8'h02: d = mk(1'b1, 1'b0, 1'b1, F_ONOFF);
      8'h19: d = mk(1'b1, 1'b0, 1'b0, F_CAP);
      8'h20: d = mk(1'b1, 1'b0, 1'b0, F_VMODE);
      8'h98: d = mk(1'b1, 1'b0, 1'b0, F_REV);
      8'hD1: d = mk(1'b1, 1'b1, 1'b1, F_MODE);
      8'h25: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_MHI);
      8'h26: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_MLO);
      8'h40: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_HIFLT);
      8'h42: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_HIWRN);
      8'h43: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_UVWRN);
      8'h44: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_UVFLT);
      8'h5E: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_PGON);
      8'h5F: if (!temp) d = mk(1'b1, 1'b1, 1'b1, F_PGOFF);
      8'h8B: if (!temp) d = mk(1'b1, 1'b1, 1'b0, F_MEAS);
      8'hD7: if (!temp) d = mk(1'b1, 1'b1, 1'b0, F_VMIN);
      8'h4F: if (temp)  d = mk(1'b1, 1'b1, 1'b1, F_HIFLT);
      8'h51: if (temp)  d = mk(1'b1, 1'b1, 1'b1, F_HIWRN);
      8'h8D: if (temp)  d = mk(1'b1, 1'b1, 1'b0, F_MEAS);
      default: d = mk(1'b0, 1'b1, 1'b0, F_NONE);
    endcase
    return d;
  endfunction

  function automatic logic [15:0] lower16(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rmb_cmd_dec.sv
module rmb_cmd_dec
  import rmb_pkg::*;
#(
  parameter int NUM_VOUT = 16,
  parameter int PW       = 5
) (
  input  logic [7:0]    cmd,
  input  logic [PW-1:0] page_idx,
  output logic          is_temp,
  output dec_t          dec
);
  assign is_temp = (page_idx >= PW'(NUM_VOUT));
  assign dec     = decode_cmd(cmd, is_temp);
endmodule

// File: rtl/rmb_page_ctx.sv
module rmb_page_ctx
  import rmb_pkg::*;
#(
  parameter bit          IS_TEMP    = 1'b0,
  parameter logic [15:0] TEMP_RESET = 16'd2500,
  parameter logic [15:0] HI_RESET   = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  fld_e        wr_fld,
  input  logic [15:0] wr_val,
  input  logic        meas_en,
  input  logic [15:0] meas_val,
  output ctx_t        ctx
);
  localparam logic [15:0] MEAS_RESET = IS_TEMP ? TEMP_RESET : 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx       <= '0;
      ctx.hflt  <= HI_RESET;
      ctx.hwrn  <= HI_RESET;
      ctx.meas  <= MEAS_RESET;
      ctx.vmin  <= HI_RESET;
    end else begin
      if (wr_en) begin
        case (wr_fld)
          F_OPER:  ctx.oper  <= wr_val[7:0];
          F_ONOFF: ctx.onoff <= wr_val[7:0];
          F_MHI:   ctx.mhi   <= wr_val;
          F_MLO:   ctx.mlo   <= wr_val;
          F_HIFLT: ctx.hflt  <= wr_val;
          F_HIWRN: ctx.hwrn  <= wr_val;
          F_UVWRN: ctx.uvw   <= wr_val;
          F_UVFLT: ctx.uvf   <= wr_val;
          F_PGON:  ctx.pgon  <= wr_val;
          F_PGOFF: ctx.pgoff <= wr_val;
          F_MODE:  ctx.mode  <= wr_val;
          default: ;
        endcase
      end
      if (meas_en) begin
        ctx.meas <= meas_val;
        if (!IS_TEMP) ctx.vmin <= lower16(ctx.vmin, meas_val);
      end
    end
  end

  // R8: the lowest-voltage record never rises
  p_vmin_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ctx.vmin <= $past(ctx.vmin));

  // R6: readings change only through the measurement port
  p_meas_port_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> $stable(ctx.meas));
endmodule

// File: rtl/pmbus_paged_regs.sv
module pmbus_paged_regs
  import rmb_pkg::*;
#(
  parameter int         NUM_VOUT  = 16,
  parameter int         NUM_TEMP  = 5,
  parameter logic [7:0] ALL_PAGES = 8'hFF,
  parameter logic [7:0] CAP_VAL   = 8'h20,
  parameter logic [7:0] VMODE_VAL = 8'h40,
  parameter logic [7:0] REV_VAL   = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cmd,
  input  logic        wr_en,
  input  logic [1:0]  wr_cnt,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic        meas_valid,
  input  logic [4:0]  meas_chan,
  input  logic [15:0] meas_value,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic [1:0]  rd_len,
  output logic        rd_err,
  output logic        wr_err
);
  localparam int NPAGE = NUM_VOUT + NUM_TEMP;
  localparam int PW    = 5;

  logic [7:0]    page_q;
  logic          all_sel;
  logic [PW-1:0] eff;
  logic          is_temp;
  dec_t          dec;
  ctx_t          ctx_a [NPAGE];
  ctx_t          sel;
  logic [15:0]   rval;

  // named events for the assertions
  logic wr_len_ok, wr_fire, wr_reject, bcast, page_legal;

  assign all_sel = (page_q == ALL_PAGES);
  assign eff     = all_sel ? '0 : page_q[PW-1:0];

  rmb_cmd_dec #(.NUM_VOUT(NUM_VOUT), .PW(PW)) u_dec (
    .cmd(cmd), .page_idx(eff), .is_temp(is_temp), .dec(dec)
  );

  assign wr_len_ok  = (wr_cnt == (dec.word ? 2'd2 : 2'd1));
  assign wr_reject  = wr_en && !(dec.known && wr_len_ok);
  assign wr_fire    = wr_en && dec.known && wr_len_ok && dec.wr_ok;
  assign bcast      = all_sel && (dec.fld == F_ONOFF || dec.fld == F_MODE);
  assign page_legal = (wr_data[7:0] < 8'(NPAGE)) || (wr_data[7:0] == ALL_PAGES);

  always_ff @(posedge clk) begin
    if (!rst_n) page_q <= '0;
    else if (wr_fire && dec.fld == F_PAGE && page_legal) page_q <= wr_data[7:0];
  end

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    logic hit;
    assign hit = wr_fire && (dec.fld != F_PAGE) && (bcast || eff == PW'(g));
    rmb_page_ctx #(.IS_TEMP(g >= NUM_VOUT)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .wr_en(hit), .wr_fld(dec.fld), .wr_val(wr_data),
      .meas_en(meas_valid && meas_chan == PW'(g)), .meas_val(meas_value),
      .ctx(ctx_a[g])
    );
  end

  always_comb begin
    sel = ctx_a[eff];
    case (dec.fld)
      F_PAGE:  rval = {8'h00, page_q};
      F_OPER:  rval = {8'h00, sel.oper};
      F_ONOFF: rval = {8'h00, sel.onoff};
      F_CAP:   rval = {8'h00, CAP_VAL};
      F_VMODE: rval = {8'h00, VMODE_VAL};
      F_REV:   rval = {8'h00, REV_VAL};
      F_MHI:   rval = sel.mhi;
      F_MLO:   rval = sel.mlo;
      F_HIFLT: rval = sel.hflt;
      F_HIWRN: rval = sel.hwrn;
      F_UVWRN: rval = sel.uvw;
      F_UVFLT: rval = sel.uvf;
      F_PGON:  rval = sel.pgon;
      F_PGOFF: rval = sel.pgoff;
      F_MEAS:  rval = sel.meas;
      F_MODE:  rval = sel.mode;
      F_VMIN:  rval = sel.vmin;
      default: rval = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_len   <= '0;
      rd_err   <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= dec.known ? rval : 16'hFFFF;
      rd_len   <= (dec.known && !dec.word) ? 2'd1 : 2'd2;
      rd_err   <= rd_en && !dec.known;
      wr_err   <= wr_reject;
    end
  end

  // R4: selector only ever holds a real page or the broadcast code
  p_page_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q < 8'(NPAGE)) || (page_q == ALL_PAGES));

  // R9: unimplemented reads answer with all-ones and an error
  p_unknown_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dec.known) |=> (rd_err && rd_data == 16'hFFFF && rd_len == 2'd2));

  // R9: bad writes are flagged
  p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_err);

  // R10: reply appears exactly one cycle after the request
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R5: broadcast of the mode word leaves first and last page equal
  p_bcast_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bcast && dec.fld == F_MODE && !meas_valid) |=>
      (ctx_a[0].mode == ctx_a[NPAGE-1].mode));

  // R6: a read-only write leaves the selected context untouched
  p_ro_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.known && !dec.wr_ok && !meas_valid) |=> ($stable(page_q) && $stable(sel)));

  // R7: format code is fixed
  p_vmode_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dec.fld == F_VMODE) |=> (rd_data == {8'h00, VMODE_VAL}));
endmodule

// File: tb/test_pmbus_paged_regs.sv
module test_pmbus_paged_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_cnt = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        meas_valid = 1'b0;
  logic [4:0]  meas_chan = '0;
  logic [15:0] meas_value = '0;
  logic        rd_valid, rd_err, wr_err;
  logic [15:0] rd_data;
  logic [1:0]  rd_len;

  always #5 clk = ~clk;

  pmbus_paged_regs i_pmbus_paged_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_en(wr_en), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .rd_en(rd_en), .meas_valid(meas_valid),
    .meas_chan(meas_chan), .meas_value(meas_value), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_len(rd_len), .rd_err(rd_err), .wr_err(wr_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  // behavioural model
  int pg;
  int oper[21], onoff[21], mhi[21], mlo[21], hf[21], hw[21];
  int uvw[21], uvf[21], pgon[21], pgoff[21], mode[21], meas[21], vmin[21];
  bit exp_rv, exp_re, exp_we;
  int exp_rd, exp_len;
  string exp_tag = "R1";

  function automatic bit known(int c, bit t);
    case (c)
      'h00, 'h01, 'h02, 'h19, 'h20, 'h98, 'hD1: return 1'b1;
      'h25, 'h26, 'h40, 'h42, 'h43, 'h44, 'h5E, 'h5F, 'h8B, 'hD7: return !t;
      'h4F, 'h51, 'h8D: return t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_byte(int c);
    return c == 'h00 || c == 'h01 || c == 'h02 || c == 'h19 || c == 'h20 || c == 'h98;
  endfunction

  function automatic bit is_ro(int c);
    return c == 'h19 || c == 'h20 || c == 'h98 || c == 'h8B || c == 'h8D || c == 'hD7;
  endfunction

  function automatic int mval(int p, int c);
    case (c)
      'h00: return pg;
      'h01: return oper[p];
      'h02: return onoff[p];
      'h19: return 'h20;
      'h20: return 'h40;
      'h98: return 'h11;
      'h25: return mhi[p];
      'h26: return mlo[p];
      'h40, 'h4F: return hf[p];
      'h42, 'h51: return hw[p];
      'h43: return uvw[p];
      'h44: return uvf[p];
      'h5E: return pgon[p];
      'h5F: return pgoff[p];
      'h8B, 'h8D: return meas[p];
      'hD1: return mode[p];
      default: return vmin[p];
    endcase
  endfunction

  task automatic mset(int p, int c, int d);
    case (c)
      'h01: oper[p] = d & 'hFF;
      'h02: onoff[p] = d & 'hFF;
      'h25: mhi[p] = d;
      'h26: mlo[p] = d;
      'h40, 'h4F: hf[p] = d;
      'h42, 'h51: hw[p] = d;
      'h43: uvw[p] = d;
      'h44: uvf[p] = d;
      'h5E: pgon[p] = d;
      'h5F: pgoff[p] = d;
      'hD1: mode[p] = d;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    int ep, c;
    if (!rst_n) begin
      pg = 0;
      for (int p = 0; p < 21; p++) begin
        oper[p] = 0; onoff[p] = 0; mhi[p] = 0; mlo[p] = 0;
        hf[p] = 'h7FFF; hw[p] = 'h7FFF; uvw[p] = 0; uvf[p] = 0;
        pgon[p] = 0; pgoff[p] = 0; mode[p] = 0;
        meas[p] = (p >= 16) ? 2500 : 0; vmin[p] = 'h7FFF;
      end
      exp_rv = 0; exp_re = 0; exp_we = 0;
    end else begin
      ep = (pg == 255) ? 0 : pg;
      c = int'(cmd);
      exp_tag = cur_tag;
      exp_rv = rd_en;
      if (rd_en) begin
        if (known(c, ep >= 16)) begin
          exp_rd = mval(ep, c); exp_len = is_byte(c) ? 1 : 2; exp_re = 0;
        end else begin
          exp_rd = 'hFFFF; exp_len = 2; exp_re = 1;
        end
      end
      exp_we = 0;
      if (wr_en) begin
        if (!known(c, ep >= 16) || int'(wr_cnt) != (is_byte(c) ? 1 : 2)) exp_we = 1;
        else if (c == 0) begin
          if ((wr_data & 'hFF) < 21 || (wr_data & 'hFF) == 255) pg = wr_data & 'hFF;
        end else if (!is_ro(c)) begin
          if (pg == 255 && (c == 'h02 || c == 'hD1))
            for (int p = 0; p < 21; p++) mset(p, c, wr_data);
          else mset(ep, c, wr_data);
        end
      end
      if (meas_valid && meas_chan < 21) begin
        meas[meas_chan] = meas_value;
        if (meas_chan < 16 && meas_value < vmin[meas_chan]) vmin[meas_chan] = meas_value;
      end
    end
  end

  // compare on every clock after reset
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (rd_valid !== exp_rv || wr_err !== exp_we) begin
        n_fail++;
        $display("FAIL %s valid/wr_err got %b/%b exp %b/%b", exp_tag, rd_valid, wr_err, exp_rv, exp_we);
      end else if (exp_rv && (rd_data !== 16'(exp_rd) || rd_len !== 2'(exp_len) || rd_err !== exp_re)) begin
        n_fail++;
        $display("FAIL %s data/len/err got %h/%0d/%b exp %h/%0d/%b", exp_tag,
                 rd_data, rd_len, rd_err, 16'(exp_rd), exp_len, exp_re);
      end
    end
  end

  task automatic rd(input int c, input string tag);
    @(negedge clk); cur_tag = tag; cmd = 8'(c); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input int c, input int d, input int n, input string tag);
    @(negedge clk); cur_tag = tag; cmd = 8'(c); wr_data = 16'(d); wr_cnt = 2'(n); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ms(input int ch, input int v, input string tag);
    @(negedge clk); cur_tag = tag; meas_chan = 5'(ch); meas_value = 16'(v); meas_valid = 1'b1;
    @(negedge clk); meas_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (rd_valid !== 1'b0 || wr_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle outputs got %b/%b exp 0/0", rd_valid, wr_err);
    end
    // R1 defaults on rail and sensor pages
    rd('h00, "R1"); rd('h40, "R1"); rd('h42, "R1"); rd('h43, "R1"); rd('h44, "R1");
    rd('hD7, "R1"); rd('h8B, "R1");
    wr('h00, 16, 1, "R1"); rd('h8D, "R1"); rd('h4F, "R1"); rd('h51, "R1");
    // R7 constants, R2 byte width
    rd('h20, "R7"); rd('h98, "R7"); rd('h19, "R7");
    // R3 read/write per page
    wr('h00, 11, 1, "R3"); rd('h00, "R3");
    wr('h01, 1, 1, "R3"); wr('h25, 5000, 2, "R3"); wr('h26, 4000, 2, "R3");
    wr('h40, 5500, 2, "R3"); wr('h42, 5600, 2, "R3"); wr('h44, 5700, 2, "R3");
    wr('h43, 5800, 2, "R3"); wr('h5E, 5900, 2, "R3"); wr('h5F, 6100, 2, "R3");
    rd('h01, "R3"); rd('h25, "R3"); rd('h26, "R3"); rd('h40, "R3"); rd('h42, "R3");
    rd('h44, "R3"); rd('h43, "R3"); rd('h5E, "R3"); rd('h5F, "R3");
    // R2 byte order: distinct bytes
    wr('hD1, 'hA55A, 2, "R2"); rd('hD1, "R2");
    wr('h00, 3, 1, "R3"); rd('h40, "R3"); rd('hD1, "R3");
    wr('h00, 18, 1, "R3"); wr('h4F, 6000, 2, "R3"); wr('h51, 5000, 2, "R3");
    rd('h4F, "R3"); rd('h51, "R3");
    // R4 illegal page values
    wr('h00, 21, 1, "R4"); rd('h00, "R4"); wr('h00, 'h80, 1, "R4"); rd('h00, "R4");
    wr('h00, 20, 1, "R4"); rd('h00, "R4");
    // R6 read-only discards
    wr('h8D, 'hABBA, 2, "R6"); rd('h8D, "R6");
    wr('h00, 1, 1, "R6"); wr('h19, 'hF9, 1, "R6"); rd('h19, "R6");
    wr('h8B, 'hDEAD, 2, "R6"); rd('h8B, "R6"); wr('hD7, 0, 2, "R6"); rd('hD7, "R6");
    wr('h20, 0, 1, "R6"); rd('h20, "R6");
    // R8 measurements
    ms(1, 3001, "R8"); rd('h8B, "R8"); rd('hD7, "R8");
    ms(1, 4000, "R8"); rd('h8B, "R8"); rd('hD7, "R8");
    ms(1, 2000, "R8"); rd('hD7, "R8");
    ms(17, 'hBE01, "R8"); ms(25, 77, "R8");
    wr('h00, 17, 1, "R8"); rd('h8D, "R8");
    // R10 read with concurrent measurement returns old value
    @(negedge clk); cur_tag = "R10"; cmd = 8'h8D; rd_en = 1'b1;
    meas_chan = 5'd17; meas_value = 16'h1234; meas_valid = 1'b1;
    @(negedge clk); rd_en = 1'b0; meas_valid = 1'b0;
    rd('h8D, "R10");
    // R9 unknown and mismatched accesses
    rd('h7A, "R9"); rd('h40, "R9"); rd('h25, "R9");
    wr('h7A, 1, 1, "R9"); wr('h4F, 1234, 1, "R9"); rd('h4F, "R9");
    wr('h00, 2, 2, "R9"); rd('h00, "R9"); wr('h01, 3, 0, "R9");
    wr('h00, 0, 1, "R9"); rd('h4F, "R9");
    // R5 broadcast
    wr('h00, 'hFF, 1, "R5"); rd('h00, "R5");
    wr('h02, 'h12, 1, "R5"); wr('hD1, 'h3456, 2, "R5"); wr('h26, 777, 2, "R5");
    rd('h26, "R5");
    for (int p = 0; p < 21; p++) begin
      wr('h00, p, 1, "R5"); rd('h02, "R5"); rd('hD1, "R5"); rd('h26, p < 16 ? "R5" : "R9");
    end
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule